// File: doc/BRIEF.md
# Wide Register Split-Access Bridge

This block sits between an 8-bit processor bus and a peripheral that has one 16-bit register and one 24-bit register. A narrow bus cannot move a wide value in one transfer. If each byte went straight into or out of the live register, software could see or create a torn value. The bridge prevents this with one shared 8-bit holding byte. On the write side, the middle byte (byte 1) is parked in the holding byte. The later write of byte 0 then commits byte 0 and byte 1 together in a single cycle. On the read side, reading byte 0 snapshots the live byte 1 into the holding byte, so the byte-1 read that follows returns a value from the same instant.

The holding byte also has an address of its own and works as an ordinary read/write register. Software can save and restore it around an interrupt that itself uses split accesses. The top byte (byte 2) of the 24-bit register does not pass through the holding byte. It is read and written directly. The peripheral samples a load output on the rising clock edge during which it is high.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, the holding byte and the bus read data are both 0x00.
- R2: A write to address 5 stores the byte in the holding byte. A read of address 5 returns the holding byte on `bus_rdata` in the cycle after the read strobe.
- R3: A write to address 1 (16-bit register, byte 1) stores the byte in the holding byte only. `w16_load` stays low during that write.
- R4: A write to address 0 (16-bit register, byte 0) raises `w16_load` in the same cycle. At the same time `w16_val` carries the holding byte in bits 15:8 and the written byte in bits 7:0.
- R5: A read of address 0 returns bits 7:0 of `w16_cur` and copies bits 15:8 of `w16_cur` into the holding byte at the same clock edge.
- R6: A read of address 1 returns the holding byte, not the live bits 15:8 of `w16_cur`.
- R7: A write to address 3 (24-bit register, byte 1) goes into the holding byte only. A write to address 2 (byte 0) raises `w24_bytes_en` to 3'b011 in the same cycle, with `w24_val[15:8]` equal to the holding byte and `w24_val[7:0]` equal to the written byte.
- R8: A write to address 4 (24-bit register, byte 2) raises `w24_bytes_en` to 3'b100 with `w24_val[23:16]` equal to the written byte, and leaves the holding byte unchanged.
- R9: A read of address 2 returns `w24_cur[7:0]` and copies `w24_cur[15:8]` into the holding byte. A read of address 3 returns the holding byte. A read of address 4 returns the live `w24_cur[23:16]`.
- R10: A direct write to address 5 between the two halves of a split access replaces the byte that the second half commits (write) or returns (read).
- R11: When read and write strobes hit address 5 in the same cycle, the read returns the previous holding byte and the holding byte takes the new value.
- R12: Addresses 6 to 15 are unmapped. Reads of them return 0x00, and writes to them raise no load and leave the holding byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address on the narrow bus |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, one cycle per byte |
| bus_re | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_re` |
| w16_cur | input | 16 | Live value of the 16-bit peripheral register |
| w16_load | output | 1 | Load pulse for the 16-bit register |
| w16_val | output | 16 | Value to load into the 16-bit register |
| w24_cur | input | 24 | Live value of the 24-bit peripheral register |
| w24_bytes_en | output | 3 | Per-byte load enables for the 24-bit register |
| w24_val | output | 24 | Value to load into the 24-bit register |

## Verification
The load outputs are combinational from the write strobe. They are due in the same cycle as the strobe, so the bench drives each strobe just after a falling edge and samples the loads 2 ns later, before the rising edge that commits the access. Read data and holding-byte updates take effect at the rising edge that ends the strobe cycle. The bench therefore reads `bus_rdata` at the next falling edge, and the effect of a snapshot or parked byte is checked through the following bus access. Sweeps run many byte patterns through every address, and the expected bytes come from the patterns themselves.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_W16_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] A_W16_HI  = 4'd1;
    localparam logic [ADDR_W-1:0] A_W24_LO  = 4'd2;
    localparam logic [ADDR_W-1:0] A_W24_MID = 4'd3;
    localparam logic [ADDR_W-1:0] A_W24_TOP = 4'd4;
    localparam logic [ADDR_W-1:0] A_TMP     = 4'd5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_W16_LO,
        SEL_W16_HI,
        SEL_W24_LO,
        SEL_W24_MID,
        SEL_W24_TOP,
        SEL_TMP
    } sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        sel_e              sel;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            A_W16_LO:  return SEL_W16_LO;
            A_W16_HI:  return SEL_W16_HI;
            A_W24_LO:  return SEL_W24_LO;
            A_W24_MID: return SEL_W24_MID;
            A_W24_TOP: return SEL_W24_TOP;
            A_TMP:     return SEL_TMP;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic parks_byte(input sel_e s);
        return (s == SEL_W16_HI) || (s == SEL_W24_MID) || (s == SEL_TMP);
    endfunction

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output bus_req_t          req
);
    always_comb begin
        req.sel  = decode_addr(addr);
        req.wr   = we && (req.sel != SEL_NONE);
        req.rd   = re;
        req.data = wdata;
    end
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold
    import wrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [BYTE_W-1:0] w16_mid,
    input  logic [BYTE_W-1:0] w24_mid,
    output logic [BYTE_W-1:0] hold_q
);
    logic              upd;
    logic [BYTE_W-1:0] nxt;

    always_comb begin
        upd = 1'b0;
        nxt = hold_q;
        if (req.wr && parks_byte(req.sel)) begin
            upd = 1'b1;
            nxt = req.data;
        end else if (req.rd && req.sel == SEL_W16_LO) begin
            upd = 1'b1;
            nxt = w16_mid;
        end else if (req.rd && req.sel == SEL_W24_LO) begin
            upd = 1'b1;
            nxt = w24_mid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (upd)
            hold_q <= nxt;
    end
endmodule

// File: rtl/wrb_commit.sv
module wrb_commit
    import wrb_pkg::*;
#(
    parameter int W16_BYTES = 2,
    parameter int W24_BYTES = 3
) (
    input  bus_req_t                      req,
    input  logic [BYTE_W-1:0]             hold_q,
    output logic                          w16_load,
    output logic [W16_BYTES*BYTE_W-1:0]   w16_val,
    output logic [W24_BYTES-1:0]          w24_bytes_en,
    output logic [W24_BYTES*BYTE_W-1:0]   w24_val
);
    logic commit16, commit24, top24;

    assign commit16 = req.wr && req.sel == SEL_W16_LO;
    assign commit24 = req.wr && req.sel == SEL_W24_LO;
    assign top24    = req.wr && req.sel == SEL_W24_TOP;

    assign w16_load = commit16;
    assign w16_val  = {hold_q, req.data};
    assign w24_val  = {req.data, hold_q, req.data};

    for (genvar b = 0; b < W24_BYTES; b++) begin : g_en
        if (b < 2) begin : g_pair
            assign w24_bytes_en[b] = commit24;
        end else begin : g_direct
            assign w24_bytes_en[b] = top24;
        end
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] w16_cur,
    output logic        w16_load,
    output logic [15:0] w16_val,
    input  logic [23:0] w24_cur,
    output logic [2:0]  w24_bytes_en,
    output logic [23:0] w24_val
);
    bus_req_t          req;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] rd_mux;

    wrb_decode u_dec (
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .we    (bus_we),
        .re    (bus_re),
        .req   (req)
    );

    wrb_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .w16_mid (w16_cur[15:8]),
        .w24_mid (w24_cur[15:8]),
        .hold_q  (hold_q)
    );

    wrb_commit #(.W16_BYTES(2), .W24_BYTES(3)) u_commit (
        .req          (req),
        .hold_q       (hold_q),
        .w16_load     (w16_load),
        .w16_val      (w16_val),
        .w24_bytes_en (w24_bytes_en),
        .w24_val      (w24_val)
    );

    always_comb begin
        case (req.sel)
            SEL_W16_LO:  rd_mux = w16_cur[7:0];
            SEL_W24_LO:  rd_mux = w24_cur[7:0];
            SEL_W24_TOP: rd_mux = w24_cur[23:16];
            SEL_W16_HI,
            SEL_W24_MID,
            SEL_TMP:     rd_mux = hold_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (req.rd)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker
    import wrb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_we,
    input logic        bus_re,
    input logic [7:0]  bus_rdata,
    input logic [15:0] w16_cur,
    input logic        w16_load,
    input logic [15:0] w16_val,
    input logic [23:0] w24_cur,
    input logic [2:0]  w24_bytes_en,
    input logic [23:0] w24_val,
    input logic [7:0]  hold_q
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (hold_q == 8'h00 && bus_rdata == 8'h00)); // R1

    AST_HOLD_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_we && bus_addr == A_TMP)
        |-> hold_q == $past(bus_wdata)); // R2

    AST_W16_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_we && bus_addr == A_W16_HI)
        && bus_we && bus_addr == A_W16_LO
        |-> w16_load && w16_val == {$past(bus_wdata), bus_wdata}); // R4

    AST_W16_SNAP: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_re && !bus_we && bus_addr == A_W16_LO)
        |-> hold_q == $past(w16_cur[15:8]) && bus_rdata == $past(w16_cur[7:0])); // R5

    AST_W24_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_we && bus_addr == A_W24_MID)
        && bus_we && bus_addr == A_W24_LO
        |-> w24_bytes_en == 3'b011 && w24_val[15:0] == {$past(bus_wdata), bus_wdata}); // R7

    AST_W24_TOP_WR: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && bus_we && bus_addr == A_W24_TOP
        |=> hold_q == $past(hold_q)); // R8

    AST_W24_TOP_VAL: assert property (@(posedge clk) disable iff (rst)
        w24_bytes_en == 3'b100 |-> w24_val[23:16] == bus_wdata); // R8

    AST_W24_READS: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_re && !bus_we && bus_addr == A_W24_LO)
        |-> hold_q == $past(w24_cur[15:8]) && bus_rdata == $past(w24_cur[7:0])); // R9

    AST_W24_TOP_RD: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_re && bus_addr == A_W24_TOP)
        |-> bus_rdata == $past(w24_cur[23:16])); // R9

    AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) && $past(bus_addr > A_TMP)
        |-> hold_q == $past(hold_q)
            && !$past(w16_load) && $past(w24_bytes_en) == 3'b000); // R12

endmodule

bind wide_reg_bridge wrb_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_rdata    (bus_rdata),
    .w16_cur      (w16_cur),
    .w16_load     (w16_load),
    .w16_val      (w16_val),
    .w24_cur      (w24_cur),
    .w24_bytes_en (w24_bytes_en),
    .w24_val      (w24_val),
    .hold_q       (hold_q)
);

// File: tb/wide_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] w16_cur = '0;
    logic        w16_load;
    logic [15:0] w16_val;
    logic [23:0] w24_cur = '0;
    logic [2:0]  w24_bytes_en;
    logic [23:0] w24_val;

    int n_chk = 0;
    int n_bad = 0;

    logic        s_ld16;
    logic [15:0] s_v16;
    logic [2:0]  s_en24;
    logic [23:0] s_v24;

    always #4 clk = ~clk;

    wide_reg_bridge dut_i (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .w16_cur(w16_cur), .w16_load(w16_load), .w16_val(w16_val),
        .w24_cur(w24_cur), .w24_bytes_en(w24_bytes_en), .w24_val(w24_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_op(input logic [3:0] a, input logic [7:0] d, input logic w, input logic r);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = w;
        bus_re    = r;
        #2;
        s_ld16 = w16_load;
        s_v16  = w16_val;
        s_en24 = w24_bytes_en;
        s_v24  = w24_val;
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rdata", {24'd0, bus_rdata}, 32'h0);
        bus_op(4'd5, 8'h00, 1'b0, 1'b1);
        chk("R1 hold", {24'd0, bus_rdata}, 32'h0);

        for (int v = 0; v < 256; v += 17) begin
            bus_op(4'd5, v[7:0], 1'b1, 1'b0);
            bus_op(4'd5, 8'h00, 1'b0, 1'b1);
            chk("R2 hold rw", {24'd0, bus_rdata}, v);
        end

        for (int i = 0; i < 16; i++) begin
            logic [7:0] hi, lo;
            hi = 8'((i * 37 + 5) & 255);
            lo = 8'((i * 91 + 11) & 255);
            bus_op(4'd1, hi, 1'b1, 1'b0);
            chk("R3 no load on byte1", {31'd0, s_ld16}, 32'd0);
            bus_op(4'd0, lo, 1'b1, 1'b0);
            chk("R4 load", {31'd0, s_ld16}, 32'd1);
            chk("R4 value", {16'd0, s_v16}, {16'd0, hi, lo});
        end

        for (int i = 0; i < 16; i++) begin
            logic [15:0] p;
            p = 16'((i * 4099 + 777) & 16'hffff);
            w16_cur = p;
            bus_op(4'd0, 8'h00, 1'b0, 1'b1);
            chk("R5 low live", {24'd0, bus_rdata}, {24'd0, p[7:0]});
            w16_cur = ~p;
            bus_op(4'd1, 8'h00, 1'b0, 1'b1);
            chk("R6 high snapshot", {24'd0, bus_rdata}, {24'd0, p[15:8]});
        end

        for (int i = 0; i < 16; i++) begin
            logic [7:0] mid, lo, top;
            mid = 8'((i * 53 + 9) & 255);
            lo  = 8'((i * 29 + 200) & 255);
            top = 8'((i * 71 + 3) & 255);
            bus_op(4'd3, mid, 1'b1, 1'b0);
            chk("R7 no load on byte1", {29'd0, s_en24}, 32'd0);
            bus_op(4'd2, lo, 1'b1, 1'b0);
            chk("R7 enables", {29'd0, s_en24}, 32'b011);
            chk("R7 value", {16'd0, s_v24[15:0]}, {16'd0, mid, lo});
            bus_op(4'd4, top, 1'b1, 1'b0);
            chk("R8 enables", {29'd0, s_en24}, 32'b100);
            chk("R8 value", {24'd0, s_v24[23:16]}, {24'd0, top});
            bus_op(4'd5, 8'h00, 1'b0, 1'b1);
            chk("R8 hold kept", {24'd0, bus_rdata}, {24'd0, mid});
        end

        for (int i = 0; i < 16; i++) begin
            logic [23:0] p;
            p = 24'((i * 1234567 + 4321) & 24'hffffff);
            w24_cur = p;
            bus_op(4'd2, 8'h00, 1'b0, 1'b1);
            chk("R9 byte0 live", {24'd0, bus_rdata}, {24'd0, p[7:0]});
            w24_cur = ~p;
            bus_op(4'd3, 8'h00, 1'b0, 1'b1);
            chk("R9 byte1 snapshot", {24'd0, bus_rdata}, {24'd0, p[15:8]});
            bus_op(4'd4, 8'h00, 1'b0, 1'b1);
            chk("R9 byte2 live", {24'd0, bus_rdata}, {24'd0, ~p[23:16]});
        end

        bus_op(4'd1, 8'hA1, 1'b1, 1'b0);
        bus_op(4'd5, 8'h5C, 1'b1, 1'b0);
        bus_op(4'd0, 8'h33, 1'b1, 1'b0);
        chk("R10 write override", {16'd0, s_v16}, 32'h5C33);
        w16_cur = 16'hBEEF;
        bus_op(4'd0, 8'h00, 1'b0, 1'b1);
        bus_op(4'd5, 8'h77, 1'b1, 1'b0);
        bus_op(4'd1, 8'h00, 1'b0, 1'b1);
        chk("R10 read override", {24'd0, bus_rdata}, 32'h77);
        bus_op(4'd3, 8'hC4, 1'b1, 1'b0);
        bus_op(4'd5, 8'h19, 1'b1, 1'b0);
        bus_op(4'd2, 8'hE2, 1'b1, 1'b0);
        chk("R10 write override 24", {16'd0, s_v24[15:0]}, 32'h19E2);

        bus_op(4'd5, 8'h2B, 1'b1, 1'b0);
        bus_op(4'd5, 8'hD6, 1'b1, 1'b1);
        chk("R11 old value read", {24'd0, bus_rdata}, 32'h2B);
        bus_op(4'd5, 8'h00, 1'b0, 1'b1);
        chk("R11 new value kept", {24'd0, bus_rdata}, 32'hD6);

        for (int a = 6; a < 16; a++) begin
            bus_op(a[3:0], 8'(a * 13), 1'b1, 1'b0);
            chk("R12 no w16 load", {31'd0, s_ld16}, 32'd0);
            chk("R12 no w24 load", {29'd0, s_en24}, 32'd0);
            bus_op(a[3:0], 8'h00, 1'b0, 1'b1);
            chk("R12 read zero", {24'd0, bus_rdata}, 32'd0);
            bus_op(4'd5, 8'h00, 1'b0, 1'b1);
            chk("R12 hold kept", {24'd0, bus_rdata}, 32'hD6);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule